// File: doc/BRIEF.md
# Card Command Issue and Interrupt Status Unit

This unit sits between a byte-wide host register port and the engine that talks to a memory card. The host starts a card command with five byte writes to the command offset. The first byte carries the opcode, and the next four carry the 32-bit argument, highest byte first. After the fifth byte the unit hands the opcode and argument to the engine with a one-cycle start strobe. It then holds a busy flag until the engine signals that the exchange has finished. Command bytes that arrive while busy is set are discarded.

The same unit keeps the interrupt state. Single-cycle event pulses from the engine and the data FIFO are latched into a status register. Reading that register returns the latched bits, with a summary pending flag in the top bit, and clears them. A writable enable mask decides which latched bits drive the level interrupt output.

Top module: `card_cmd_irq`

## Requirements
- R1: After reset, busy, start and irq are 0, the status register reads 0x00, the enable register reads 0x78, and the byte counter is at the first byte.
- R2: Five writes to offset 0x00 form one command. The first byte's bits 5:0 become the opcode. Bytes two to five become argument bits 31:24, 23:16, 15:8 and 7:0 in that order. Opcode and argument are valid when start is high. Start is high for exactly one cycle, the cycle after the clock edge that takes the fifth byte.
- R3: Busy rises together with start and stays high until an engine done pulse arrives while busy is set. Busy is low in the cycle after that edge.
- R4: A write to offset 0x00 while busy is set is ignored and leaves opcode and argument unchanged. After each complete command the counter returns to the first byte, so the next five writes form a fresh command.
- R5: An event pulse on evt[i] sets status bit i at the clock edge. The bits are: 6 card change, 5 FIFO, 4 CRC error, 3 timeout, 2 programming end, 1 busy end, 0 transfer complete. A set bit stays set until the register is read.
- R6: A read of offset 0x03 returns {pending, status[6:0]}. The read clears the latched bits at that edge, except for an event pulsing in the same cycle, which is kept.
- R7: irq is 1 exactly when some status bit is set whose enable bit is also set. Status bit 7 (pending) equals irq. A value of 0x00 means nothing is pending.
- R8: A write to offset 0x02 loads enable bits 6:0 with the same bit map as the status register. Written bit 7 is dropped and reads as 0. A disabled event still latches but does not raise irq.
- R9: Reads of any offset other than 0x02 and 0x03, or with rd_en low, return 0x00. Writes to other offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_en | input | 1 | Register read strobe (a status read clears) |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Read byte, combinational from rd_en and rd_addr |
| evt | input | 7 | Event pulses, bit map as in R5 |
| eng_done | input | 1 | Engine exchange finished |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_opcode | output | 6 | Command opcode |
| cmd_arg | output | 32 | Command argument |
| busy | output | 1 | Card-traffic busy flag |
| irq | output | 1 | Level interrupt |

## Verification
Each write and each event takes effect at the clock edge that samples it. Start, busy, opcode, argument, the status bits and irq all show the new value in the cycle right after that edge. rd_data is combinational, so it shows the register contents in the same cycle the read is presented. The clear-on-read acts at the edge that ends that cycle. The bench drives inputs one time unit after a rising edge. It samples outputs either just after that edge, for registered results, or one time unit after setting up a read, before the next edge. This keeps every check at the cycle where the result is due.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;

    localparam int OFS_W       = 3;
    localparam logic [OFS_W-1:0] OFS_CMD   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_IEN   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_ISTAT = 3'd3;

    localparam int EVT_W = 7;

    // Bit order is visible to software through the status register.
    typedef struct packed {
        logic card_chg;   // 6
        logic fifo;       // 5
        logic crc_err;    // 4
        logic tmo;        // 3
        logic prog_end;   // 2
        logic busy_end;   // 1
        logic xfer_done;  // 0
    } evt_t;

    localparam evt_t IEN_RESET = '{card_chg: 1'b1, fifo: 1'b1, crc_err: 1'b1,
                                   tmo: 1'b1, prog_end: 1'b0, busy_end: 1'b0,
                                   xfer_done: 1'b0};

    function automatic logic any_enabled(input evt_t st, input evt_t en);
        return |(st & en);
    endfunction

endpackage

// File: rtl/cmd_byte_collector.sv
module cmd_byte_collector #(
    parameter int OP_W      = 6,
    parameter int ARG_BYTES = 4,
    localparam int ARG_W    = ARG_BYTES * 8,
    localparam int IDX_W    = $clog2(ARG_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_we,
    input  logic [7:0]       byte_in,
    input  logic             done,
    output logic             start,
    output logic             busy,
    output logic [OP_W-1:0]  opcode,
    output logic [ARG_W-1:0] arg
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ARG_BYTES);

    logic [IDX_W-1:0] idx_q;
    logic [ARG_W-1:0] arg_shift;

    generate
        if (ARG_BYTES == 1) begin : g_single
            assign arg_shift = byte_in;
        end else begin : g_multi
            assign arg_shift = {arg[ARG_W-9:0], byte_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            start  <= 1'b0;
            busy   <= 1'b0;
            opcode <= '0;
            arg    <= '0;
        end else begin
            start <= 1'b0;
            if (busy) begin
                if (done) busy <= 1'b0;
            end else if (byte_we) begin
                if (idx_q == '0) begin
                    opcode <= byte_in[OP_W-1:0];
                    idx_q  <= idx_q + 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    arg   <= arg_shift;
                    idx_q <= '0;
                    start <= 1'b1;
                    busy  <= 1'b1;
                end else begin
                    arg   <= arg_shift;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import card_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  logic clr,
    input  logic en_we,
    input  evt_t en_din,
    output evt_t stat_q,
    output evt_t en_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= IEN_RESET;
        end else begin
            stat_q <= clr ? evt : (stat_q | evt);
            if (en_we) en_q <= en_din;
        end
    end

    assign irq = any_enabled(stat_q, en_q);
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux
    import card_cmd_pkg::*;
(
    input  logic             rd_en,
    input  logic [OFS_W-1:0] rd_addr,
    input  evt_t             stat,
    input  evt_t             en,
    input  logic             pending,
    output logic [7:0]       rd_data
);
    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            unique case (rd_addr)
                OFS_IEN:   rd_data = {1'b0, en};
                OFS_ISTAT: rd_data = {pending, stat};
                default:   rd_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/card_cmd_irq.sv
module card_cmd_irq
    import card_cmd_pkg::*;
#(
    parameter int OP_W      = 6,
    parameter int ARG_BYTES = 4,
    localparam int ARG_W    = ARG_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [2:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic [6:0]       evt,
    input  logic             eng_done,
    output logic             cmd_start,
    output logic [OP_W-1:0]  cmd_opcode,
    output logic [ARG_W-1:0] cmd_arg,
    output logic             busy,
    output logic             irq
);
    evt_t stat_q;
    evt_t en_q;
    logic cmd_we;
    logic ien_we;
    logic stat_clr;

    assign cmd_we   = wr_en && (wr_addr == OFS_CMD);
    assign ien_we   = wr_en && (wr_addr == OFS_IEN);
    assign stat_clr = rd_en && (rd_addr == OFS_ISTAT);

    cmd_byte_collector #(.OP_W(OP_W), .ARG_BYTES(ARG_BYTES)) u_coll (
        .clk     (clk),
        .rst     (rst),
        .byte_we (cmd_we),
        .byte_in (wr_data),
        .done    (eng_done),
        .start   (cmd_start),
        .busy    (busy),
        .opcode  (cmd_opcode),
        .arg     (cmd_arg)
    );

    irq_status_unit u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_t'(evt)),
        .clr    (stat_clr),
        .en_we  (ien_we),
        .en_din (evt_t'(wr_data[6:0])),
        .stat_q (stat_q),
        .en_q   (en_q),
        .irq    (irq)
    );

    reg_read_mux u_rd (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .stat    (stat_q),
        .en      (en_q),
        .pending (irq),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/card_cmd_irq_chk.sv
module card_cmd_irq_chk #(
    parameter int OP_W  = 6,
    parameter int ARG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [2:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic [6:0]       evt,
    input logic             eng_done,
    input logic             cmd_start,
    input logic [OP_W-1:0]  cmd_opcode,
    input logic [ARG_W-1:0] cmd_arg,
    input logic             busy,
    input logic             irq,
    input logic [6:0]       stat_bits
);
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> busy);

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> busy);

    p_busy_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done) |=> !busy);

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !cmd_start);

    p_cmd_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_start) |-> ($stable(cmd_arg) && $stable(cmd_opcode)));

    p_evt_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (evt != 7'd0) |=> ((stat_bits & $past(evt)) == $past(evt)));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 3'd3 && evt == 7'd0) |=> (stat_bits == 7'd0));

    p_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 3'd3) |-> (rd_data[7] == irq));
endmodule

bind card_cmd_irq card_cmd_irq_chk #(.OP_W(OP_W), .ARG_W(ARG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .evt        (evt),
    .eng_done   (eng_done),
    .cmd_start  (cmd_start),
    .cmd_opcode (cmd_opcode),
    .cmd_arg    (cmd_arg),
    .busy       (busy),
    .irq        (irq),
    .stat_bits  (stat_q)
);

// File: tb/sim_card_cmd_irq.sv
`timescale 1ns/1ps
module sim_card_cmd_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [6:0]  evt = '0;
    logic        eng_done = 1'b0;
    logic        cmd_start;
    logic [5:0]  cmd_opcode;
    logic [31:0] cmd_arg;
    logic        busy;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    card_cmd_irq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt(evt),
        .eng_done(eng_done), .cmd_start(cmd_start), .cmd_opcode(cmd_opcode),
        .cmd_arg(cmd_arg), .busy(busy), .irq(irq)
    );

    // {first byte, argument}
    localparam logic [39:0] CMD_VEC [5] = '{
        {8'h11, 32'h0000_0200},
        {8'hD8, 32'hDEAD_BEEF},
        {8'h00, 32'h0000_0000},
        {8'h3F, 32'hFFFF_FFFF},
        {8'h19, 32'h8000_0001}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        step();
        rd_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [6:0] m);
        evt = m;
        step();
        evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5:0] op_prev;
        logic [31:0] arg_prev;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 start", cmd_start, 0);
        check("R1 irq", irq, 0);
        rd(3'd2, v); check("R1 enable default", v, 8'h78);
        rd(3'd3, v); check("R1 status zero", v, 8'h00);

        // R2/R3/R4 vector walk
        for (int i = 0; i < 5; i++) begin
            logic [39:0] vec;
            vec = CMD_VEC[i];
            wr(3'd0, vec[39:32]);
            check("R2 no early start", cmd_start, 0);
            for (int b = 3; b >= 1; b--) wr(3'd0, vec[b*8 +: 8]);
            check("R2 no start after four", cmd_start, 0);
            wr(3'd0, vec[7:0]);
            check("R2 start", cmd_start, 1);
            check("R2 opcode", cmd_opcode, vec[37:32]);
            check("R2 arg", cmd_arg, vec[31:0]);
            check("R3 busy set", busy, 1);
            step();
            check("R2 start one cycle", cmd_start, 0);
            op_prev = cmd_opcode; arg_prev = cmd_arg;
            // R4 writes while busy are ignored
            for (int k = 0; k < 6; k++) wr(3'd0, 8'hA5 ^ 8'(k));
            check("R4 busy ignore start", cmd_start, 0);
            check("R4 busy ignore arg", cmd_arg, arg_prev);
            check("R4 busy ignore op", cmd_opcode, op_prev);
            check("R3 busy held", busy, 1);
            eng_done = 1'b1; step(); eng_done = 1'b0;
            check("R3 busy clear", busy, 0);
        end

        // R9 writes to other offsets do nothing
        for (int k = 0; k < 5; k++) wr(3'd1, 8'h55);
        check("R9 no start other offset", busy, 0);
        rd(3'd1, v); check("R9 other offset reads zero", v, 8'h00);
        rd_en = 1'b0; rd_addr = 3'd3; #1;
        check("R9 rd_en low zero", rd_data, 8'h00);

        // R5/R7 enabled event
        pulse_evt(7'b000_1000);
        check("R7 irq on timeout", irq, 1);
        rd(3'd3, v); check("R6 status read timeout", v, 8'h88);
        check("R6 cleared irq", irq, 0);
        rd(3'd3, v); check("R6 status cleared", v, 8'h00);

        // R8 disabled event latches without irq
        pulse_evt(7'b000_0001);
        check("R8 disabled no irq", irq, 0);
        pulse_evt(7'b100_0000);
        check("R5 card change irq", irq, 1);
        rd(3'd3, v); check("R5 two bits kept", v, 8'hC1);

        // R8 enable write, bit 7 dropped
        wr(3'd2, 8'hFF);
        rd(3'd2, v); check("R8 enable readback", v, 8'h7F);
        pulse_evt(7'b000_0001);
        check("R8 enabled xfer irq", irq, 1);

        // R6 event during read survives
        rd_en = 1'b1; rd_addr = 3'd3; evt = 7'b000_0010;
        #1 check("R6 read value pre edge", rd_data, 8'h81);
        step(); rd_en = 1'b0; evt = '0;
        rd(3'd3, v); check("R6 same cycle event kept", v, 8'h82);

        // R8 mask off everything
        wr(3'd2, 8'h00);
        pulse_evt(7'h7F);
        check("R8 all masked", irq, 0);
        rd(3'd3, v); check("R7 pending low masked", v, 8'h7F);

        // R1 reset mid-command
        wr(3'd0, 8'h05); wr(3'd0, 8'h01);
        rst = 1'b1; step(); rst = 1'b0;
        for (int k = 0; k < 4; k++) wr(3'd0, 8'h10 + 8'(k));
        check("R1 counter reset", cmd_start, 0);
        wr(3'd0, 8'h99);
        check("R1 fresh command start", cmd_start, 1);
        check("R1 fresh opcode", cmd_opcode, 6'h10);
        check("R1 fresh arg", cmd_arg, 32'h1112_1399);
        rd(3'd2, v); check("R1 enable restored", v, 8'h78);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule